// File: doc/BRIEF.md
# Addressed Serial Frame Receiver and Key Reader

This block is the host-facing serial port of a segment display controller that also scans a key matrix. A host talks to it over three wires (a chip-enable, a serial clock and a data input) and watches one open-drain data output. With chip-enable low the host clocks in an 8-bit address. It then raises chip-enable and either sends a 56-bit write frame or clocks out the latest key data. A write frame carries 42 segment bits plus a trailer. The trailer's last two bits choose which third of the 126-bit display memory the segment bits go to. The trailer of the first third also carries eight mode bits.

A frame takes effect only at the falling edge of chip-enable, and only when exactly 56 bits were clocked. When no transfer is running, the data output works as an interrupt line: the key scanner signals new key data, and the block pulls the line low until the host reads the data. After a power-on reset the block holds a reset flag. The flag stays set until each of the three display thirds has been written at least once. While the flag is set, the data output stays released and key requests are dropped. The serial interface still accepts frames during that period.

All serial inputs are assumed to be already synchronised to `clk`, and each level is held for at least one `clk` cycle. The serial clock may rest either low or high between transfers.

Top module: `serial_frame_rx`

## Requirements
- R1: Address bits are sampled on serial clock rising edges while chip-enable is low, least significant bit first. Address 42h opens a write and 43h opens a read. Any other address makes the transfer that follows have no effect on display memory or mode bits, and the data output stays high while chip-enable is high.
- R2: In a write frame, serial bit 1 lands in the lowest segment bit of the selected third. The direction is formed as {bit 55, bit 56}. Direction 00 selects display bits 0–41, 01 selects bits 42–83, 10 selects bits 84–125, and 11 discards the frame.
- R3: A direction-00 frame also loads its bits 47–54 into sleep_mode[0], sleep_mode[1], keyout_mode[0], keyout_mode[1], port_mode[0], port_mode[1], seg_blank and half_bias, in that order. Bits 43–46 are ignored.
- R4: Display memory and mode outputs change only in the cycle after a chip-enable falling edge.
- R5: A write transfer with a bit count other than 56 is discarded.
- R6: While chip-enable is low and the reset flag is clear, the data output is low exactly when a key request is pending. A pulse on key_ready makes a request pending.
- R7: During a read, the data output presents KD1 (key_bits[0]) from the rise of chip-enable onward. It moves to the next bit on each serial clock falling edge that follows an unmatched rising edge. Bit k is therefore valid at rising edge k. The order is KD1 to KD30, then a sleep bit that is 1 when sleep_mode is nonzero. After those 31 bits the output is high.
- R8: Writes and reads give the same result whether the serial clock rests low or high around the chip-enable edges.
- R9: A pending request is cleared by the chip-enable falling edge that ends a read with at least 31 rising edges. A shorter read leaves the request pending.
- R10: While chip-enable is high in a write or an unknown-address transfer, the data output is high.
- R11: After rst_n, reset_hold is 1, display memory and mode bits are zero and the data output is high. reset_hold drops in the cycle after the chip-enable falling edge that completes the last of the three thirds, and it never rises again without rst_n.
- R12: While reset_hold is 1 the data output is high, and key_ready pulses are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ser_ce | input | 1 | Chip-enable; low for address, high for data |
| ser_clk | input | 1 | Serial clock, either resting level |
| ser_din | input | 1 | Serial data in, sampled on serial clock rise |
| ser_dout | output | 1 | Open-drain data out level (1 = released) |
| key_bits | input | 30 | Key matrix state from the scanner, bit 0 = KD1 |
| key_ready | input | 1 | Pulse: scanner has new confirmed key data |
| disp_bits | output | 126 | Display memory, bit 0 = first segment bit |
| sleep_mode | output | 2 | Sleep selection bits |
| keyout_mode | output | 2 | Key-output/segment sharing selection |
| port_mode | output | 2 | Segment/general-output selection |
| seg_blank | output | 1 | All segments off |
| half_bias | output | 1 | 1 selects the half-bias drive |
| reset_hold | output | 1 | Power-on reset period still active |

## Verification
The hardest state to reach from the ports is the exit from the reset period. It needs three accepted frames with three distinct directions. Along the way the block must ignore a short frame, a frame with an unknown address and a frame with direction 11, and none of these may count toward the exit. The stimulus therefore writes the first two thirds, then sends each of the rejected frames aimed at the last third, and only then sends the valid last frame. The checks confirm that reset_hold drops on that final chip-enable edge and not earlier. Read transfers are run with both clock resting levels, and with too few and too many clock edges, so that the bit pointer, the end-of-read clearing and the released line after bit 31 are all exercised.

// File: rtl/sfr_pkg.sv
// Shared definitions for the addressed serial frame receiver.
package sfr_pkg;
    // Kind of transfer opened by the address byte
    typedef enum logic [1:0] {
        XFER_NONE  = 2'd0,
        XFER_WRITE = 2'd1,
        XFER_READ  = 2'd2
    } xfer_t;

    // Number of mode bits carried by the first-third frame
    localparam int CTRL_W = 8;
endpackage

// File: rtl/sfr_front.sv
// Serial front end: edge detection on chip-enable and serial clock, address
// collection while chip-enable is low, data shifting and edge counting while
// it is high. Assumes inputs are already synchronous to clk and that
// chip-enable and serial clock never change in the same cycle.
module sfr_front
    import sfr_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] WR_ADDR    = 8'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR    = 8'h43,
    parameter int                FRAME_BITS = 56,
    parameter int                CNT_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic                  sclk,
    input  logic                  sdi,
    output logic                  ce_q,
    output logic                  ce_rise,
    output logic                  ce_fall,
    output logic                  sclk_fall,
    output xfer_t                 mode,
    output logic [CNT_W-1:0]      rise_cnt,
    output logic [FRAME_BITS-1:0] shreg
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              sclk_q;
    logic              sclk_rise;
    logic [ADDR_W-1:0] addr;

    assign ce_rise   = ce & ~ce_q;
    assign ce_fall   = ~ce & ce_q;
    assign sclk_rise = sclk & ~sclk_q;
    assign sclk_fall = ~sclk & sclk_q;

    // Keep last-cycle levels of the serial control lines for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            ce_q   <= ce;
            sclk_q <= sclk;
        end
    end

    // Collect the address LSB first while chip-enable is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ce_fall) begin
            addr <= '0;
        end else if (!ce_q && sclk_rise) begin
            addr <= {sdi, addr[ADDR_W-1:1]};
        end
    end

    // Decode the transfer kind when chip-enable rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= XFER_NONE;
        end else if (ce_rise) begin
            if (addr == WR_ADDR)      mode <= XFER_WRITE;
            else if (addr == RD_ADDR) mode <= XFER_READ;
            else                      mode <= XFER_NONE;
        end else if (ce_fall) begin
            mode <= XFER_NONE;
        end
    end

    // Shift data bits in (first bit ends at index 0) and count rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            shreg    <= '0;
        end else if (ce_rise) begin
            rise_cnt <= '0;
        end else if (ce_q && sclk_rise) begin
            shreg <= {sdi, shreg[FRAME_BITS-1:1]};
            if (rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfr_store.sv
// Frame store: at the falling edge of chip-enable, commits a complete write
// frame into the display third chosen by its trailing direction bits, loads
// mode bits from the first-third frame, and ends the power-on reset period
// once every third has been written. Assumes the shift register holds the
// first serial bit at index 0.
module sfr_store
    import sfr_pkg::*;
#(
    parameter int SEGS_PER_FRAME = 42,
    parameter int NUM_FRAMES     = 3,
    parameter int FRAME_BITS     = 56,
    parameter int CNT_W          = 7
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ce_fall,
    input  xfer_t                                mode,
    input  logic [CNT_W-1:0]                     rise_cnt,
    input  logic [FRAME_BITS-1:0]                shreg,
    output logic [SEGS_PER_FRAME*NUM_FRAMES-1:0] disp,
    output logic [CTRL_W-1:0]                    ctrl,
    output logic                                 in_reset
);
    localparam int DIR_W    = $clog2(NUM_FRAMES);
    localparam int CTRL_LSB = FRAME_BITS - DIR_W - CTRL_W;

    logic [DIR_W-1:0]      dir;
    logic                  accept;
    logic [NUM_FRAMES-1:0] seen;
    logic [NUM_FRAMES-1:0] seen_next;

    // Direction value: first trailing bit is the most significant
    always_comb begin
        for (int i = 0; i < DIR_W; i++) begin
            dir[DIR_W-1-i] = shreg[FRAME_BITS-DIR_W+i];
        end
    end

    assign accept    = ce_fall && (mode == XFER_WRITE)
                       && (rise_cnt == CNT_W'(FRAME_BITS))
                       && (int'(dir) < NUM_FRAMES);
    assign seen_next = seen | (NUM_FRAMES'(1) << dir);

    // One display third per direction value
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_third
        // Commit segment bits of an accepted frame aimed at this third
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                disp[g*SEGS_PER_FRAME +: SEGS_PER_FRAME] <= '0;
            end else if (accept && (dir == DIR_W'(g))) begin
                disp[g*SEGS_PER_FRAME +: SEGS_PER_FRAME] <= shreg[SEGS_PER_FRAME-1:0];
            end
        end
    end

    // Mode bits come only with the first-third frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (accept && (dir == '0)) begin
            ctrl <= shreg[CTRL_LSB +: CTRL_W];
        end
    end

    // Track written thirds and leave the reset period when all are present
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= '0;
            in_reset <= 1'b1;
        end else if (accept) begin
            seen <= seen_next;
            if (&seen_next) in_reset <= 1'b0;
        end
    end
endmodule

// File: rtl/sfr_keyrd.sv
// Key reader: holds the key-read request, snapshots key data at the start of
// each transfer, walks a bit pointer on serial clock falling edges during a
// read, and forms the data output level. Assumes a pointer step is only taken
// after a matching rising edge, so either resting clock level works.
module sfr_keyrd
    import sfr_pkg::*;
#(
    parameter int KEY_BITS = 30,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_q,
    input  logic                ce_rise,
    input  logic                ce_fall,
    input  logic                sclk_fall,
    input  xfer_t               mode,
    input  logic [CNT_W-1:0]    rise_cnt,
    input  logic [KEY_BITS-1:0] key_bits,
    input  logic                key_ready,
    input  logic                sleep_any,
    input  logic                in_reset,
    output logic                sdo,
    output logic                req
);
    localparam int RD_BITS = KEY_BITS + 1;
    localparam int PTR_W   = $clog2(RD_BITS + 1);

    logic [RD_BITS-1:0] snap;
    logic [PTR_W-1:0]   ptr;
    logic               rd_done;
    logic               cur_bit;

    assign rd_done = ce_fall && (mode == XFER_READ) && (rise_cnt >= CNT_W'(RD_BITS));
    assign cur_bit = (int'(ptr) < RD_BITS) ? snap[ptr] : 1'b1;

    // Capture key data and sleep state when a transfer starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (ce_rise) begin
            snap <= {sleep_any, key_bits};
        end
    end

    // Advance the read pointer on a falling edge that follows a rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ce_rise) begin
            ptr <= '0;
        end else if (ce_q && sclk_fall && (int'(ptr) < RD_BITS)
                     && (CNT_W'(ptr) < rise_cnt)) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Request is raised by the scanner and dropped by a completed read
    always_ff @(posedge clk) begin
        if (!rst_n || in_reset) begin
            req <= 1'b0;
        end else if (key_ready) begin
            req <= 1'b1;
        end else if (rd_done) begin
            req <= 1'b0;
        end
    end

    // Output level: released in reset, request while idle, data while reading
    always_comb begin
        if (in_reset)                sdo = 1'b1;
        else if (!ce_q)              sdo = ~req;
        else if (mode == XFER_READ)  sdo = cur_bit;
        else                         sdo = 1'b1;
    end
endmodule

// File: rtl/serial_frame_rx.sv
// Top level of the addressed serial frame receiver and key reader. Ties the
// serial front end, the frame store and the key reader together. Assumes the
// serial inputs are synchronous to clk.
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int                SEGS_PER_FRAME = 42,
    parameter int                NUM_FRAMES     = 3,
    parameter int                TAIL_BITS      = 14,
    parameter int                KEY_BITS       = 30,
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] WR_ADDR        = 8'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR        = 8'h43
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ser_ce,
    input  logic                                 ser_clk,
    input  logic                                 ser_din,
    output logic                                 ser_dout,
    input  logic [KEY_BITS-1:0]                  key_bits,
    input  logic                                 key_ready,
    output logic [SEGS_PER_FRAME*NUM_FRAMES-1:0] disp_bits,
    output logic [1:0]                           sleep_mode,
    output logic [1:0]                           keyout_mode,
    output logic [1:0]                           port_mode,
    output logic                                 seg_blank,
    output logic                                 half_bias,
    output logic                                 reset_hold
);
    localparam int FRAME_BITS = SEGS_PER_FRAME + TAIL_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1) + 1;

    logic                  ce_q;
    logic                  ce_rise;
    logic                  ce_fall;
    logic                  sclk_fall;
    xfer_t                 mode;
    logic [CNT_W-1:0]      rise_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [CTRL_W-1:0]     ctrl;
    logic                  key_req;

    sfr_front #(
        .ADDR_W(ADDR_W), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR),
        .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
    ) u_front (
        .clk(clk), .rst_n(rst_n), .ce(ser_ce), .sclk(ser_clk), .sdi(ser_din),
        .ce_q(ce_q), .ce_rise(ce_rise), .ce_fall(ce_fall), .sclk_fall(sclk_fall),
        .mode(mode), .rise_cnt(rise_cnt), .shreg(shreg)
    );

    sfr_store #(
        .SEGS_PER_FRAME(SEGS_PER_FRAME), .NUM_FRAMES(NUM_FRAMES),
        .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .ce_fall(ce_fall), .mode(mode),
        .rise_cnt(rise_cnt), .shreg(shreg), .disp(disp_bits), .ctrl(ctrl),
        .in_reset(reset_hold)
    );

    sfr_keyrd #(
        .KEY_BITS(KEY_BITS), .CNT_W(CNT_W)
    ) u_keyrd (
        .clk(clk), .rst_n(rst_n), .ce_q(ce_q), .ce_rise(ce_rise),
        .ce_fall(ce_fall), .sclk_fall(sclk_fall), .mode(mode),
        .rise_cnt(rise_cnt), .key_bits(key_bits), .key_ready(key_ready),
        .sleep_any(|ctrl[1:0]), .in_reset(reset_hold), .sdo(ser_dout),
        .req(key_req)
    );

    assign sleep_mode  = ctrl[1:0];
    assign keyout_mode = ctrl[3:2];
    assign port_mode   = ctrl[5:4];
    assign seg_blank   = ctrl[6];
    assign half_bias   = ctrl[7];
endmodule

// File: rtl/sfr_checker.sv
// Protocol checker for serial_frame_rx, attached by bind. Observes the data
// output, the reset flag, the display memory and the request state.
module sfr_checker
    import sfr_pkg::*;
#(
    parameter int DISP_BITS = 126
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce_q,
    input logic                 ce_fall,
    input xfer_t                mode,
    input logic                 key_req,
    input logic                 ser_dout,
    input logic                 reset_hold,
    input logic [DISP_BITS-1:0] disp_bits
);
    // R12: line released for the whole reset period
    assert_dout_released_in_reset_R12: assert property (
        @(posedge clk) disable iff (!rst_n) reset_hold |-> ser_dout);

    // R10: line released while chip-enable is high outside a read
    assert_dout_high_nonread_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (ce_q && mode != XFER_READ) |-> ser_dout);

    // R4: display memory moves only after a chip-enable falling edge
    assert_disp_holds_R4: assert property (
        @(posedge clk) disable iff (!rst_n) !ce_fall |=> $stable(disp_bits));

    // R11: once left, the reset period does not return without rst_n
    assert_reset_sticky_R11: assert property (
        @(posedge clk) disable iff (!rst_n) !reset_hold |=> !reset_hold);

    // R9: a request only drops at the end of a transfer
    assert_req_clears_at_end_R9: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(key_req) |-> $past(ce_fall));
endmodule

bind serial_frame_rx sfr_checker #(
    .DISP_BITS(SEGS_PER_FRAME*NUM_FRAMES)
) u_sfr_checker (
    .clk(clk), .rst_n(rst_n), .ce_q(ce_q), .ce_fall(ce_fall), .mode(mode),
    .key_req(key_req), .ser_dout(ser_dout), .reset_hold(reset_hold),
    .disp_bits(disp_bits)
);

// File: tb/tb_serial_frame_rx.sv
`timescale 1ns/1ps
module tb_serial_frame_rx;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce = 1'b0;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    logic [29:0]  key_bits = '0;
    logic         key_ready = 1'b0;
    logic         ser_dout;
    logic [125:0] disp_bits;
    logic [1:0]   sleep_mode, keyout_mode, port_mode;
    logic         seg_blank, half_bias, reset_hold;

    serial_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .ser_ce(ce), .ser_clk(sclk), .ser_din(sdi),
        .ser_dout(ser_dout), .key_bits(key_bits), .key_ready(key_ready),
        .disp_bits(disp_bits), .sleep_mode(sleep_mode), .keyout_mode(keyout_mode),
        .port_mode(port_mode), .seg_blank(seg_blank), .half_bias(half_bias),
        .reset_hold(reset_hold)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit live = 1'b0;
    bit finished = 1'b0;
    logic rise_do;

    // Behavioural reference state
    logic [125:0] m_disp;
    logic [7:0]   m_ctl;
    bit           m_rst, m_req, m_ce, m_rd, m_wr;
    logic [7:0]   m_addr;
    int           m_rises, m_armed;
    bit           m_q[$];
    bit           m_w[$];
    bit [2:0]     m_seen;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_do();
        if (m_rst) return 1'b1;
        if (!m_ce) return !m_req;
        if (m_rd && m_q.size() > 0) return m_q[0];
        return 1'b1;
    endfunction

    task automatic model_reset();
        m_disp = '0; m_ctl = '0; m_rst = 1; m_req = 0; m_ce = 0; m_rd = 0; m_wr = 0;
        m_addr = '0; m_rises = 0; m_armed = 0; m_q.delete(); m_w.delete(); m_seen = '0;
    endtask

    // Apply what the requirements say happens for the levels just driven
    task automatic model_edge(input bit pce, input bit psclk);
        if (sclk && !psclk) begin
            if (ce) begin
                m_rises++; m_armed++; m_w.push_back(sdi);
            end else begin
                m_addr = {sdi, m_addr[7:1]};
            end
        end
        if (!sclk && psclk && ce && m_rd && m_armed > 0 && m_q.size() > 0) begin
            void'(m_q.pop_front());
            m_armed--;
        end
        if (ce && !pce) begin
            m_ce = 1; m_rd = (m_addr == 8'h43); m_wr = (m_addr == 8'h42);
            m_rises = 0; m_armed = 0; m_w.delete(); m_q.delete();
            for (int k = 0; k < 30; k++) m_q.push_back(key_bits[k]);
            m_q.push_back(m_ctl[1:0] != 2'b00);
        end
        if (!ce && pce) begin
            m_ce = 0;
            if (m_wr && m_w.size() == 56) begin
                int dir;
                dir = {m_w[54], m_w[55]};
                if (dir < 3) begin
                    for (int i = 0; i < 42; i++) m_disp[dir*42+i] = m_w[i];
                    if (dir == 0) for (int i = 0; i < 8; i++) m_ctl[i] = m_w[46+i];
                    m_seen[dir] = 1'b1;
                    if (m_seen == 3'b111) m_rst = 0;
                end
            end
            if (m_rd && m_rises >= 31) m_req = 0;
            m_rd = 0; m_wr = 0; m_addr = '0;
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (live && !finished) begin
            check("R6 R7 R10 R12 dout", 128'(ser_dout), 128'(exp_do()));
            check("R2 disp", 128'(disp_bits), 128'(m_disp));
            check("R3 mode bits", 128'({half_bias, seg_blank, port_mode, keyout_mode, sleep_mode}), 128'(m_ctl));
            check("R11 reset_hold", 128'(reset_hold), 128'(m_rst));
        end
    end

    task automatic drive(input logic ce_v, input logic sclk_v, input logic sdi_v);
        bit pce, psclk;
        @(negedge clk);
        pce = ce; psclk = sclk;
        ce = ce_v; sclk = sclk_v; sdi = sdi_v;
        @(posedge clk); #1;
        model_edge(pce, psclk);
    endtask

    task automatic clk_bit(input logic b, input bit pol);
        if (!pol) begin
            drive(ce, 1'b0, b); drive(ce, 1'b1, b); rise_do = ser_dout; drive(ce, 1'b0, b);
        end else begin
            drive(ce, 1'b0, b); drive(ce, 1'b1, b); rise_do = ser_dout;
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [63:0] bits, input int n, input bit pol,
                        output logic [63:0] got, output logic dmid, output logic [125:0] prefall);
        got = '1;
        drive(1'b0, pol, 1'b0);
        for (int i = 0; i < 8; i++) clk_bit(a[i], pol);
        drive(1'b1, pol, 1'b0);
        dmid = ser_dout;
        for (int i = 0; i < n; i++) begin
            clk_bit(bits[i], pol);
            got[i] = rise_do;
        end
        drive(1'b1, pol, 1'b0);
        prefall = disp_bits;
        drive(1'b0, pol, 1'b0);
        drive(1'b0, pol, 1'b0);
    endtask

    task automatic key_pulse();
        @(negedge clk); key_ready = 1'b1;
        @(posedge clk); #1;
        if (!m_rst) m_req = 1;
        @(negedge clk); key_ready = 1'b0;
    endtask

    function automatic logic [63:0] frame(input logic [1:0] dir, input logic [41:0] d, input logic [7:0] ctl);
        logic [63:0] f;
        f = '0;
        f[41:0] = d;
        f[53:46] = ctl;
        f[54] = dir[1];
        f[55] = dir[0];
        return f;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        logic dmid;
        logic [125:0] pf;
        logic [41:0] d0, d1, d2;
        logic [29:0] k1, k2;
        d0 = 42'h2A5_C3C3_5A5A; d1 = 42'h1F0_0FF0_1234; d2 = 42'h3C9_8765_4321;
        k1 = 30'h2345_6789; k2 = 30'h1ACE_0F0F;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk); rst_n = 1'b1; live = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 reset flag", 128'(reset_hold), 128'(1));
        check("R11 display cleared", 128'(disp_bits), 128'(0));
        check("R11 dout released", 128'(ser_dout), 128'(1));
        // R12 request ignored during reset period
        key_pulse();
        repeat (2) @(negedge clk);
        check("R12 dout high in reset", 128'(ser_dout), 128'(1));

        // R2 R3 first third, clock resting low
        xfer(8'h42, frame(2'b00, d0, 8'hB4), 56, 1'b0, got, dmid, pf);
        check("R4 unchanged before CE fall", 128'(pf), 128'(0));
        check("R2 first third", 128'(disp_bits[41:0]), 128'(d0));
        check("R3 mode bits", 128'({half_bias, seg_blank, port_mode, keyout_mode, sleep_mode}), 128'(8'hB4));
        // R8 second third, clock resting high
        xfer(8'h42, frame(2'b01, d1, 8'h00), 56, 1'b1, got, dmid, pf);
        check("R8 second third rest-high", 128'(disp_bits[83:42]), 128'(d1));
        // R5 short frame discarded
        xfer(8'h42, frame(2'b10, d2, 8'h00), 55, 1'b0, got, dmid, pf);
        check("R5 short frame dropped", 128'(disp_bits[125:84]), 128'(0));
        // R1 unknown address ignored
        xfer(8'h44, frame(2'b10, d2, 8'h00), 56, 1'b0, got, dmid, pf);
        check("R1 unknown address dropped", 128'(disp_bits[125:84]), 128'(0));
        check("R1 dout high in unknown transfer", 128'(dmid), 128'(1));
        // R2 direction 11 discarded
        xfer(8'h42, frame(2'b11, d2, 8'hFF), 56, 1'b0, got, dmid, pf);
        check("R2 direction 11 dropped", 128'(disp_bits), 128'({42'h0, d1, d0}));
        check("R11 still in reset", 128'(reset_hold), 128'(1));
        // R11 last third ends the reset period
        xfer(8'h42, frame(2'b10, d2, 8'h00), 56, 1'b0, got, dmid, pf);
        check("R4 unchanged before last CE fall", 128'(pf), 128'({42'h0, d1, d0}));
        check("R2 last third", 128'(disp_bits[125:84]), 128'(d2));
        check("R11 reset period over", 128'(reset_hold), 128'(0));

        // R6 request on the idle line
        check("R6 idle released", 128'(ser_dout), 128'(1));
        key_bits = k1;
        key_pulse();
        repeat (2) @(negedge clk);
        check("R6 request pulls low", 128'(ser_dout), 128'(0));
        // R7 full read, clock resting low
        xfer(8'h43, 64'h0, 31, 1'b0, got, dmid, pf);
        check("R7 read bits rest-low", 128'(got[30:0]), 128'({1'b0, k1}));
        check("R9 request cleared", 128'(ser_dout), 128'(1));
        // R9 short read keeps request
        key_pulse();
        xfer(8'h43, 64'h0, 10, 1'b0, got, dmid, pf);
        check("R9 short read keeps request", 128'(ser_dout), 128'(0));
        // R10 write while request pending; sets sleep bits for SA
        xfer(8'h42, frame(2'b00, d0, 8'h02), 56, 1'b1, got, dmid, pf);
        check("R10 dout high in write", 128'(dmid), 128'(1));
        check("R3 sleep bits", 128'(sleep_mode), 128'(2'b10));
        check("R6 request still pending", 128'(ser_dout), 128'(0));
        // R7 R8 read resting high, sleep bit set
        key_bits = k2;
        xfer(8'h43, 64'h0, 31, 1'b1, got, dmid, pf);
        check("R8 read bits rest-high", 128'(got[30:0]), 128'({1'b1, k2}));
        // R7 line high after 31 bits
        key_pulse();
        xfer(8'h43, 64'h0, 40, 1'b0, got, dmid, pf);
        check("R7 bits past the end", 128'(got[39:31]), 128'(9'h1FF));
        check("R9 long read clears", 128'(ser_dout), 128'(1));

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule